// File: doc/BRIEF.md
# Early-Terminating Radix-256 Booth Multiplier

This block is a sequential 32×32 integer multiplier for an execute stage. A start strobe captures the multiplicand, the multiplier, an optional addend and three mode selects. The block then retires eight multiplier bits per clock. Each cycle it adds one Booth-recoded digit times the shifted multiplicand into a 64-bit accumulator.

The operation stops as soon as the multiplier bits not yet consumed, together with the last bit already consumed, are all zeros or all ones. From that point the remaining Booth digits are all zero. A multiplier of small magnitude therefore finishes in one or two cycles. Long mode returns the full 64-bit signed or unsigned product. Short mode returns only the low word. When accumulate is enabled, the addend is added to the product. The cycle count of each operation is reported next to the result, so termination timing can be observed.

Top module: `booth_mult`

## Requirements
- R1: After reset `busy`, `done`, `result` and `cycles` are all zero.
- R2: With `long_en`=1 and `signed_en`=1, `result` is the exact 64-bit two's-complement product of `op_a` and `op_b`.
- R3: With `long_en`=1 and `signed_en`=0, `result` is the exact 64-bit unsigned product, including a multiplier of all ones.
- R4: With `long_en`=0, `result[31:0]` is the low 32 bits of the product, `result[63:32]` is zero, and `signed_en` has no effect on either the result or the cycle count.
- R5: With `acc_en`=1, short mode adds `addend[31:0]` modulo 2^32 and long mode adds all 64 bits of `addend` modulo 2^64. With `acc_en`=0 the addend is ignored.
- R6: The cycle count is the smallest k ≥ 1 such that bits 8k−1 and above of the extended multiplier are all equal. The multiplier is sign-extended in short mode and in signed long mode, and zero-extended in unsigned long mode.
- R7: `cycles` never exceeds 4 in short mode or 5 in long mode.
- R8: The multiplier −1 (0xFFFFFFFF) with multiplicand 18 finishes in 1 cycle in short mode and in signed long mode.
- R9: When `start` is sampled while the block is idle, `busy` is high from the next edge. `done` rises at the edge that completes iteration k, where k is the reported `cycles`, and at that edge `busy` falls.
- R10: `done` is a one-cycle pulse. `result` and `cycles` hold their values until the next operation completes.
- R11: A `start` sampled while `busy` is high is ignored: the running operation's result and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier (Booth-recoded) |
| addend | input | 64 | Accumulate value (low 32 bits used in short mode) |
| long_en | input | 1 | 1: 64-bit product, 0: low 32 bits only |
| signed_en | input | 1 | Long mode operand signedness |
| acc_en | input | 1 | Add addend to the product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Product (plus addend) |
| cycles | output | 3 | Iteration cycles used by the last operation |

## Verification
The in-RTL assertions check on every cycle that `done` is a single-cycle pulse that follows a busy cycle, that an idle start raises `busy`, and that `result` moves only on a completion edge. They also check that the reported cycle count stays within the short and long limits. Product values, the zero- or sign-extension decision, the exact early-termination cycle for each multiplier pattern, and the ignored restart can only be shown by the bench. Its behavioural model computes the product with wide integer arithmetic, derives the expected count from the multiplier bits, and compares the outputs on every clock.

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int W = 32,
  parameter int R = 8,
  localparam int EW = W + 1,
  localparam int XW = 2 * W,
  localparam int STEPS = (EW + R - 1) / R,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [XW-1:0] addend,
  input  logic          long_en,
  input  logic          signed_en,
  input  logic          acc_en,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] result,
  output logic [CW-1:0] cycles
);

  logic signed [EW-1:0] mr;
  logic                 prv;
  logic [XW-1:0]        mc;
  logic [XW-1:0]        acc;
  logic [CW-1:0]        cnt;
  logic                 long_q;

  logic signed [R:0]    digit;
  logic [XW-1:0]        dext;
  logic [XW-1:0]        acc_nx;
  logic signed [EW-1:0] mr_nx;
  logic                 fin;
  logic                 ext_b, ext_a;

  assign digit  = $signed({mr[R-1], mr[R-1:0]}) + $signed({{R{1'b0}}, prv});
  assign dext   = {{(XW-R-1){digit[R]}}, digit};
  assign acc_nx = acc + mc * dext;
  assign mr_nx  = mr >>> R;
  assign fin    = (mr_nx == '0 && !mr[R-1]) || (mr_nx == '1 && mr[R-1]);
  assign ext_b  = (signed_en || !long_en) & op_b[W-1];
  assign ext_a  = signed_en & long_en & op_a[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      cycles <= '0;
      mr     <= '0;
      prv    <= 1'b0;
      mc     <= '0;
      acc    <= '0;
      cnt    <= '0;
      long_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          mr     <= $signed({ext_b, op_b});
          prv    <= 1'b0;
          mc     <= {{W{ext_a}}, op_a};
          cnt    <= '0;
          long_q <= long_en;
          if (!acc_en)      acc <= '0;
          else if (long_en) acc <= addend;
          else              acc <= {{W{1'b0}}, addend[W-1:0]};
        end
      end else begin
        acc <= acc_nx;
        mc  <= mc << R;
        mr  <= mr_nx;
        prv <= mr[R-1];
        cnt <= cnt + 1'b1;
        if (fin) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          cycles <= cnt + 1'b1;
          result <= long_q ? acc_nx : {{W{1'b0}}, acc_nx[W-1:0]};
        end
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && !busy);
  a_r9_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(cycles));
  a_r7_cycle_limit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles >= 1) && (cycles <= (long_q ? CW'(STEPS) : CW'(W / R))));

endmodule

// File: tb/test_booth_mult.sv
`timescale 1ns/1ps
module test_booth_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [63:0] addend = '0;
  logic        long_en = 1'b0, signed_en = 1'b0, acc_en = 1'b0;
  logic        busy, done;
  logic [63:0] result;
  logic [2:0]  cycles;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  booth_mult i_booth_mult (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
    .op_b(op_b), .addend(addend), .long_en(long_en), .signed_en(signed_en),
    .acc_en(acc_en), .busy(busy), .done(done), .result(result), .cycles(cycles));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [31:0] b, input bit lng, input bit sgn);
    longint v = (sgn || !lng) ? longint'($signed(b)) : longint'({32'b0, b});
    for (int k = 1; k <= 5; k++) begin
      longint r = v >>> (8 * k - 1);
      if (r == 0 || r == -1) return k;
    end
    return 5;
  endfunction

  function automatic logic [63:0] exp_res(input logic [31:0] a, input logic [31:0] b,
      input logic [63:0] ad, input bit lng, input bit sgn, input bit acc);
    longint pa = (lng && sgn) ? longint'($signed(a)) : longint'({32'b0, a});
    longint pb = (lng && sgn) ? longint'($signed(b)) : longint'({32'b0, b});
    logic [63:0] p = 64'(pa * pb);
    if (lng) return p + (acc ? ad : 64'd0);
    return {32'b0, p[31:0] + (acc ? ad[31:0] : 32'd0)};
  endfunction

  // Runs one operation and compares every clock against the model.
  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [63:0] ad,
      input bit lng, input bit sgn, input bit acc, input string req, input bit retry);
    int k = exp_cycles(b, lng, sgn);
    logic [63:0] er = exp_res(a, b, ad, lng, sgn, acc);
    @(negedge clk);
    op_a = a; op_b = b; addend = ad; long_en = lng; signed_en = sgn; acc_en = acc; start = 1'b1;
    @(negedge clk);
    chk(busy && !done, "R9 busy after start", {62'b0, busy, done}, 64'd2);
    if (retry) begin  // R11: second start while busy, different operands
      op_a = ~a; op_b = 32'h0000_0001; addend = ~ad; long_en = ~lng; acc_en = ~acc;
    end else start = 1'b0;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done == (i == k), {req, " done timing"}, {63'b0, done}, {63'b0, i == k});
      chk(busy == (i != k), "R9 busy timing", {63'b0, busy}, {63'b0, i != k});
    end
    chk(result == er, {req, " result"}, result, er);
    chk(cycles == 3'(k), "R6 cycle count", {61'b0, cycles}, 64'(k));
    chk(cycles <= (lng ? 3'd5 : 3'd4), "R7 cycle limit", {61'b0, cycles}, 64'(lng ? 5 : 4));
    @(negedge clk);
    chk(!done && result == er && cycles == 3'(k), "R10 pulse and hold", result, er);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0 && cycles == 0, "R1 reset", result, 64'd0);
    rst_n = 1'b1;
    // R2 signed long
    op(32'hFFFF_FFF6, 32'h0001_2345, 64'd0, 1, 1, 0, "R2", 0);
    op(32'h8000_0000, 32'h8000_0000, 64'd0, 1, 1, 0, "R2", 0);
    op(32'h1234_5678, 32'hFFFF_FF80, 64'd0, 1, 1, 0, "R2", 0);
    // R3 unsigned long, all-ones multiplier needs the fifth digit
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1, 0, 0, "R3", 0);
    op(32'hDEAD_BEEF, 32'h8000_0001, 64'd0, 1, 0, 0, "R3", 0);
    // R4 short, signedness select has no effect
    op(32'h0BAD_F00D, 32'hFFFF_0003, 64'd0, 0, 0, 0, "R4 sel0", 0);
    op(32'h0BAD_F00D, 32'hFFFF_0003, 64'd0, 0, 1, 0, "R4 sel1", 0);
    // R5 accumulate, and addend ignored when acc_en=0
    op(32'h0000_1000, 32'h0000_0010, 64'hAAAA_AAAA_FFFF_FFFF, 0, 0, 1, "R5 short acc", 0);
    op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'hFFFF_FFFF_0000_0001, 1, 0, 1, "R5 long acc", 0);
    op(32'h0000_0003, 32'h0000_0005, 64'h1234_5678_9ABC_DEF0, 1, 1, 0, "R5 no acc", 0);
    // R6 termination boundaries
    op(32'h0000_0007, 32'h0000_0000, 64'd0, 1, 1, 0, "R6 zero", 0);
    op(32'h0000_0007, 32'h0000_007F, 64'd0, 1, 1, 0, "R6 0x7F", 0);
    op(32'h0000_0007, 32'h0000_0080, 64'd0, 1, 1, 0, "R6 0x80", 0);
    op(32'h0000_0007, 32'h00FF_FFFF, 64'd0, 0, 0, 0, "R6 24 ones", 0);
    // R8 18 times -1
    op(32'd18, 32'hFFFF_FFFF, 64'd0, 0, 0, 0, "R8 short", 0);
    op(32'd18, 32'hFFFF_FFFF, 64'd0, 1, 1, 0, "R8 long", 0);
    // R11 restart while busy is ignored
    op(32'h0000_0123, 32'h1234_5678, 64'd5, 1, 1, 1, "R11", 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule